// File: doc/BRIEF.md
# Accumulator Machine Timing Controller

This block is the control unit for a small accumulator machine. It does not hold a separate state for each step of each instruction. A shared four-phase timing sequence is ANDed with eight one-hot instruction lines decoded from the instruction opcode, and each product is one micro-step. Each datapath control point is the OR of the micro-steps that need it. The outputs enable the bus drivers, load the registers, load or step the program counter, set the ALU mode, write memory, and raise a stop request when the machine halts.

Every instruction uses two fetch phases (P0, P1), followed by zero, one or two execute phases (P2, P3). The datapath presents the opcode being fetched on `ir_op` from the start of P1 and holds it until the instruction's last phase, so that the decision taken at the end of P1 uses the new opcode. The `acc_zero` flag from the accumulator is looked at only during the execute phase of the conditional branch. Reset is asynchronous and active low.

Top module: `acc_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the controller is in P0 and shows the P0 pattern.
- R2: In P0 exactly `pc_drive` and `ma_load` are high (the address register takes the program counter). The next phase is P1 whatever the opcode is.
- R3: In P1 exactly `mem_drive`, `ir_load`, `ma_load` and `pc_inc` are high. The next phase is P0 for a no-op and P2 for every other instruction.
- R4: Opcode decoding: 0 = no-op, 1 = halt, 2 = load, 3 = store, 4 = jump, 5 = branch-if-zero, 6 = AND, 7 = ADD. Every opcode from 8 to 15 decodes as a no-op.
- R5: In P2, load asserts exactly `mem_drive` and `a_load`. Store asserts exactly `alu_drive`, `alu_logic` (with `alu_s0` low, which selects the A pass-through) and `mem_wr`. Both then return to P0.
- R6: In P2, jump asserts exactly `ma_drive` and `pc_load`. Branch-if-zero asserts the same pair when `acc_zero` is 1 and nothing when it is 0. Both then return to P0.
- R7: In P2, AND and ADD assert exactly `mem_drive` and `b_load`, then move to P3. In P3 they assert `alu_drive`, `a_load` and `alu_s0`, with `alu_logic` high for AND and low for ADD, and `alu_cin` stays low. Both then return to P0.
- R8: When a halt reaches P2, `halt` goes high and stays high until reset, with every other output low. Changes on `ir_op` or `acc_zero` have no effect while halted.
- R9: At most one of `mem_drive`, `alu_drive`, `pc_drive` and `ma_drive` is high in any cycle.
- R10: `mem_wr` is high only together with `alu_drive`, and `pc_load` and `pc_inc` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_op | input | OP_W | Opcode of the instruction being fetched or executed |
| acc_zero | input | 1 | High when the accumulator holds zero |
| mem_wr | output | 1 | Memory write strobe |
| mem_drive | output | 1 | Memory read data onto the bus |
| alu_drive | output | 1 | ALU result onto the bus |
| pc_drive | output | 1 | Program counter onto the bus |
| ma_drive | output | 1 | Address-register operand field onto the bus |
| alu_s0 | output | 1 | ALU operand select (1 uses B) |
| alu_cin | output | 1 | ALU carry input |
| alu_logic | output | 1 | ALU logic mode (1) or arithmetic mode (0) |
| pc_load | output | 1 | Parallel load of the program counter from the bus |
| a_load | output | 1 | Load the accumulator from the bus |
| b_load | output | 1 | Load the operand register from the bus |
| ma_load | output | 1 | Load the address register |
| ir_load | output | 1 | Load the instruction register |
| pc_inc | output | 1 | Increment the program counter |
| halt | output | 1 | Stop request, held until reset |

## Verification
Two things can fall in the same cycle: the branch-if-zero decision in P2 and a change on `acc_zero`, and likewise the fetch phases and a change on `ir_op`. The bench drives a fresh pseudo-random `acc_zero` every cycle and flips it on each branch, so the flag's value in that P2 cycle is the one that decides `pc_load`. It also puts junk on `ir_op` during P0 and while halted. A behavioural phase model predicts the full output vector on every cycle and must match it exactly. The model also checks the bus-exclusion and strobe-pairing rules on every cycle.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

   localparam int NUM_INSTR = 8;
   localparam int NUM_PHASE = 4;
   localparam int CODE_W    = $clog2(NUM_INSTR);

   localparam int I_NOP = 0;
   localparam int I_HLT = 1;
   localparam int I_LDA = 2;
   localparam int I_STA = 3;
   localparam int I_JMP = 4;
   localparam int I_BEZ = 5;
   localparam int I_AND = 6;
   localparam int I_ADD = 7;

   localparam int P0 = 0;
   localparam int P1 = 1;
   localparam int P2 = 2;
   localparam int P3 = 3;

   typedef enum logic [1:0] {PH_0 = 2'd0, PH_1 = 2'd1, PH_2 = 2'd2, PH_3 = 2'd3} phase_t;

   typedef struct packed {
      logic mem_wr;
      logic mem_drive;
      logic alu_drive;
      logic pc_drive;
      logic ma_drive;
      logic alu_s0;
      logic alu_cin;
      logic alu_logic;
      logic pc_load;
      logic a_load;
      logic b_load;
      logic ma_load;
      logic ir_load;
      logic pc_inc;
      logic halt;
   } ctl_t;

endpackage

// File: rtl/acc_ctl_decode.sv
module acc_ctl_decode
   import acc_ctl_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic [OP_W-1:0]      op,
   output logic [NUM_INSTR-1:0] instr
);

   logic in_range;

   generate
      if (OP_W > CODE_W) begin : g_wide
         assign in_range = ~|op[OP_W-1:CODE_W];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   // code zero and every out-of-range code fold onto the no-op line
   assign instr[I_NOP] = (op[CODE_W-1:0] == '0) | ~in_range;

   generate
      for (genvar i = 1; i < NUM_INSTR; i++) begin : g_line
         assign instr[i] = in_range & (op[CODE_W-1:0] == CODE_W'(i));
      end
   endgenerate

endmodule

// File: rtl/acc_ctl_seq.sv
module acc_ctl_seq
   import acc_ctl_pkg::*;
#(
   parameter bit ONE_HOT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_INSTR-1:0] instr,
   output logic [NUM_PHASE-1:0] tm,
   output logic                 stop
);

   logic                 halted_q;
   logic                 hold;
   logic                 two_step;
   logic [NUM_PHASE-1:0] nxt;

   assign two_step = instr[I_AND] | instr[I_ADD];
   assign hold     = halted_q | (tm[P2] & instr[I_HLT]);
   assign stop     = hold;

   always_comb begin
      nxt     = '0;
      nxt[P1] = tm[P0];
      nxt[P2] = tm[P1] & ~instr[I_NOP];
      nxt[P3] = tm[P2] & two_step;
      nxt[P0] = (tm[P1] & instr[I_NOP]) | (tm[P2] & ~two_step) | tm[P3];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      halted_q <= 1'b0;
      else if (tm[P2] & instr[I_HLT])  halted_q <= 1'b1;
   end

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_PHASE-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    oh_q <= NUM_PHASE'(1);
            else if (!hold) oh_q <= nxt;
         end
         assign tm = oh_q;
      end else begin : g_binary
         phase_t ph_q;
         phase_t ph_d;
         always_comb begin
            ph_d = PH_0;
            if (nxt[P1]) ph_d = PH_1;
            if (nxt[P2]) ph_d = PH_2;
            if (nxt[P3]) ph_d = PH_3;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ph_q <= PH_0;
            else if (!hold) ph_q <= ph_d;
         end
         always_comb begin
            tm       = '0;
            tm[ph_q] = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/acc_ctl_points.sv
module acc_ctl_points
   import acc_ctl_pkg::*;
(
   input  logic [NUM_PHASE-1:0] tm,
   input  logic [NUM_INSTR-1:0] instr,
   input  logic                 zero,
   input  logic                 stop,
   output ctl_t                 ctl
);

   logic [NUM_INSTR-1:0] s2;
   logic [NUM_INSTR-1:0] s3;
   logic                 run;
   logic                 take;

   // micro-steps: execute phase ANDed with each instruction line
   assign s2   = instr & {NUM_INSTR{tm[P2]}};
   assign s3   = instr & {NUM_INSTR{tm[P3]}};
   assign run  = ~stop;
   assign take = s2[I_JMP] | (s2[I_BEZ] & zero);

   always_comb begin
      ctl           = '0;
      ctl.halt      = stop;
      ctl.pc_drive  = run & tm[P0];
      ctl.ma_load   = run & (tm[P0] | tm[P1]);
      ctl.ir_load   = run & tm[P1];
      ctl.pc_inc    = run & tm[P1];
      ctl.mem_drive = run & (tm[P1] | s2[I_LDA] | s2[I_AND] | s2[I_ADD]);
      ctl.a_load    = run & (s2[I_LDA] | s3[I_AND] | s3[I_ADD]);
      ctl.b_load    = run & (s2[I_AND] | s2[I_ADD]);
      ctl.alu_drive = run & (s2[I_STA] | s3[I_AND] | s3[I_ADD]);
      ctl.alu_logic = run & (s2[I_STA] | s3[I_AND]);
      ctl.alu_s0    = run & (s3[I_AND] | s3[I_ADD]);
      ctl.alu_cin   = 1'b0;
      ctl.mem_wr    = run & s2[I_STA];
      ctl.ma_drive  = run & take;
      ctl.pc_load   = run & take;
   end

endmodule

// File: rtl/acc_ctl.sv
module acc_ctl
   import acc_ctl_pkg::*;
#(
   parameter int OP_W          = 4,
   parameter bit ONE_HOT_STATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] ir_op,
   input  logic            acc_zero,
   output logic            mem_wr,
   output logic            mem_drive,
   output logic            alu_drive,
   output logic            pc_drive,
   output logic            ma_drive,
   output logic            alu_s0,
   output logic            alu_cin,
   output logic            alu_logic,
   output logic            pc_load,
   output logic            a_load,
   output logic            b_load,
   output logic            ma_load,
   output logic            ir_load,
   output logic            pc_inc,
   output logic            halt
);

   generate
      if (OP_W < CODE_W) begin : g_bad_width
         $error("acc_ctl: OP_W must cover all instruction codes");
      end
   endgenerate

   logic [NUM_INSTR-1:0] instr;
   logic [NUM_PHASE-1:0] tm;
   logic                 stop;
   ctl_t                 ctl;

   acc_ctl_decode #(.OP_W(OP_W)) u_dec (
      .op    (ir_op),
      .instr (instr)
   );

   acc_ctl_seq #(.ONE_HOT(ONE_HOT_STATE)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .instr (instr),
      .tm    (tm),
      .stop  (stop)
   );

   acc_ctl_points u_pts (
      .tm    (tm),
      .instr (instr),
      .zero  (acc_zero),
      .stop  (stop),
      .ctl   (ctl)
   );

   assign mem_wr    = ctl.mem_wr;
   assign mem_drive = ctl.mem_drive;
   assign alu_drive = ctl.alu_drive;
   assign pc_drive  = ctl.pc_drive;
   assign ma_drive  = ctl.ma_drive;
   assign alu_s0    = ctl.alu_s0;
   assign alu_cin   = ctl.alu_cin;
   assign alu_logic = ctl.alu_logic;
   assign pc_load   = ctl.pc_load;
   assign a_load    = ctl.a_load;
   assign b_load    = ctl.b_load;
   assign ma_load   = ctl.ma_load;
   assign ir_load   = ctl.ir_load;
   assign pc_inc    = ctl.pc_inc;
   assign halt      = ctl.halt;

endmodule

// File: rtl/acc_ctl_chk.sv
module acc_ctl_chk #(
   parameter int OP_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [OP_W-1:0] ir_op,
   input logic            mem_wr,
   input logic            mem_drive,
   input logic            alu_drive,
   input logic            pc_drive,
   input logic            ma_drive,
   input logic            pc_load,
   input logic            a_load,
   input logic            b_load,
   input logic            ma_load,
   input logic            ir_load,
   input logic            pc_inc,
   input logic            halt
);

   AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_drive, alu_drive, pc_drive, ma_drive}) <= 1); // R9

   AST_WRITE_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> alu_drive); // R10

   AST_PC_LOAD_NOT_INC: assert property (@(posedge clk) disable iff (!rst_n)
      !(pc_load && pc_inc)); // R10

   AST_FETCH_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |-> $past(pc_drive && ma_load)); // R2

   AST_NOP_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_load && (ir_op == '0)) |=> (pc_drive && ma_load)); // R3

   AST_JUMP_USES_MA: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> ma_drive); // R6

   AST_ACC_AFTER_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (a_load && alu_drive) |-> $past(b_load)); // R7

   AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (halt && !ma_load && !ir_load && !pc_drive)); // R8

endmodule

bind acc_ctl acc_ctl_chk #(.OP_W(OP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ir_op     (ir_op),
   .mem_wr    (mem_wr),
   .mem_drive (mem_drive),
   .alu_drive (alu_drive),
   .pc_drive  (pc_drive),
   .ma_drive  (ma_drive),
   .pc_load   (pc_load),
   .a_load    (a_load),
   .b_load    (b_load),
   .ma_load   (ma_load),
   .ir_load   (ir_load),
   .pc_inc    (pc_inc),
   .halt      (halt)
);

// File: tb/test_acc_ctl.sv
`timescale 1ns/1ps
module test_acc_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ir_op = 4'd0;
   logic       acc_zero = 1'b0;
   logic       mem_wr, mem_drive, alu_drive, pc_drive, ma_drive, alu_s0, alu_cin;
   logic       alu_logic, pc_load, a_load, b_load, ma_load, ir_load, pc_inc, halt;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   acc_ctl i_acc_ctl (
      .clk(clk), .rst_n(rst_n), .ir_op(ir_op), .acc_zero(acc_zero),
      .mem_wr(mem_wr), .mem_drive(mem_drive), .alu_drive(alu_drive),
      .pc_drive(pc_drive), .ma_drive(ma_drive), .alu_s0(alu_s0),
      .alu_cin(alu_cin), .alu_logic(alu_logic), .pc_load(pc_load),
      .a_load(a_load), .b_load(b_load), .ma_load(ma_load),
      .ir_load(ir_load), .pc_inc(pc_inc), .halt(halt)
   );

   // bit order: mem_wr .. halt, 14 down to 0
   function automatic logic [14:0] observed();
      return {mem_wr, mem_drive, alu_drive, pc_drive, ma_drive, alu_s0, alu_cin,
              alu_logic, pc_load, a_load, b_load, ma_load, ir_load, pc_inc, halt};
   endfunction

   // phase 4 stands for the halted condition
   function automatic logic [14:0] predict(int ph, int op, bit z);
      logic [14:0] e = '0;
      case (ph)
         0: begin e[11] = 1; e[3] = 1; end
         1: begin e[13] = 1; e[2] = 1; e[3] = 1; e[1] = 1; end
         2: case (op)
               1: e[0] = 1;
               2: begin e[13] = 1; e[5] = 1; end
               3: begin e[12] = 1; e[7] = 1; e[14] = 1; end
               4: begin e[10] = 1; e[6] = 1; end
               5: if (z) begin e[10] = 1; e[6] = 1; end
               6, 7: begin e[13] = 1; e[4] = 1; end
               default: ;
            endcase
         3: begin e[12] = 1; e[5] = 1; e[9] = 1; if (op == 6) e[7] = 1; end
         default: e[0] = 1;
      endcase
      return e;
   endfunction

   function automatic int advance(int ph, int op);
      case (ph)
         0: return 1;
         1: return (op == 0 || op >= 8) ? 0 : 2;
         2: return (op == 1) ? 4 : ((op == 6 || op == 7) ? 3 : 0);
         3: return 0;
         default: return 4;
      endcase
   endfunction

   function automatic string tag_of(int ph, int op, bit in_rst);
      if (in_rst) return "R1";
      case (ph)
         0: return "R2";
         1: return (op == 0 || op >= 8) ? "R3 R4" : "R3";
         2: case (op)
               1: return "R8";
               2, 3: return "R5 R4";
               4, 5: return "R6 R4";
               default: return "R7 R4";
            endcase
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   localparam int PROG_LEN = 26;
   int prog [PROG_LEN] = '{2, 3, 4, 5, 5, 6, 7, 0, 8, 15, 12, 5, 7, 6, 3, 2, 5, 4, 1,
                            7, 6, 0, 10, 5, 2, 1};

   initial begin
      int          ph = 0;
      int          idx = 0;
      int          halted_cycles = 0;
      int          rst_cycles = 2;
      bit          bez_z = 1'b0;
      logic [15:0] lfsr = 16'hACE1;
      logic [14:0] got;
      for (int cyc = 0; cyc < 700; cyc++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (rst_cycles > 0) begin
            rst_n = 1'b0;
            ph = 0;
            rst_cycles--;
         end else begin
            rst_n = 1'b1;
         end
         // opcode: junk in P0 and while halted, new instruction in P1, held after
         if (ph == 1) begin
            ir_op = 4'(prog[idx]);
            idx = (idx + 1) % PROG_LEN;
         end else if (ph == 0 || ph == 4) begin
            ir_op = lfsr[7:4];
         end
         if (ph == 2 && ir_op == 4'd5) begin
            bez_z = ~bez_z;
            acc_zero = bez_z;
         end else begin
            acc_zero = lfsr[0];
         end
         #1;
         got = observed();
         check(tag_of(ph, int'(ir_op), !rst_n), got, predict(ph, int'(ir_op), acc_zero));
         check("R9", {3'b0, 12'($countones({mem_drive, alu_drive, pc_drive, ma_drive}) > 1)}, '0);
         check("R10", {13'b0, mem_wr & ~alu_drive, pc_load & pc_inc}, '0);
         if (rst_n) ph = advance(ph, int'(ir_op));
         if (ph == 4) begin
            halted_cycles++;
            if (halted_cycles == 6) begin
               halted_cycles = 0;
               rst_cycles = 2;
            end
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule